// File: doc/BRIEF.md
# Tuner PLL Synthesizer Digital Core

This block holds the counting and comparison logic of a frequency synthesizer that sets a tuner's local oscillator. Oscillator edges enter as single-cycle strobes on `osc_tick_i`. They pass through a fixed divide-by-eight prescaler and then a 15-bit main divider, so the divided signal has a period of 8·N oscillator edges. Crystal edges enter as strobes on `xtal_tick_i` and drive a reference divider with a ratio of 512, 640 or 1024. Both strobes are sampled in the `clk_i` domain.

A phase/frequency detector compares the two divided pulse trains and issues pump-up and pump-down requests. A lock monitor measures how long these requests last in each comparison period and raises a lock indication. When automatic current switching is enabled, the monitor also forces the charge-pump current select to low while the loop is locked. A test output can show either the reference pulse train or the divided signal halved in frequency. A new divider value or reference ratio is taken up only when the running count ends, so no period is ever shortened.

Top module: `tuner_pll_core`

## Requirements
- R1: The divided signal has a period of exactly 8·N oscillator strobes, where N is `n_i`.
- R2: Values of `n_i` below 2 are treated as 2, giving a period of 16 oscillator strobes.
- R3: The reference period in crystal strobes is set by `ratio_i`: 2'b00 gives 512, 2'b01 gives 640, and 2'b10 or 2'b11 gives 1024.
- R4: When the reference leads, `up_o` is high and `dn_o` stays low. When the divided signal leads, `dn_o` is high and `up_o` stays low. The two are never high together, and pulses that arrive in the same cycle cancel.
- R5: Lock is declared after 4 consecutive comparison periods in which the up/down request lasted fewer than 2 crystal strobes. While locked, `lock_flag_o` is 1 and `lock_n_o` is 0.
- R6: A comparison period whose request lasts 2 or more crystal strobes clears lock at the end of that period.
- R7: `cp_hi_o` is 0 when `auto_cp_i` is 1 and the loop is locked. In every other case `cp_hi_o` follows `cp_hi_i`.
- R8: With `test_en_i` low, `test_o` stays 0. With `test_en_i` high and `test_sel_i` at 0, `test_o` gives one pulse per reference period. With `test_sel_i` at 1, `test_o` toggles once per divided period, so it has one rising edge every two divided periods.
- R9: During reset, `up_o`, `dn_o`, `lock_flag_o` and `test_o` are 0, and `lock_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator edge |
| xtal_tick_i | input | 1 | One-cycle strobe per crystal edge |
| n_i | input | 15 | Main divider value N |
| ratio_i | input | 2 | Reference ratio select |
| cp_hi_i | input | 1 | Programmed charge-pump current (1 = high) |
| auto_cp_i | input | 1 | Enables the drop to low current while locked |
| test_en_i | input | 1 | Enables the test output |
| test_sel_i | input | 1 | Test source: 0 = reference, 1 = half divided signal |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| cp_hi_o | output | 1 | Effective charge-pump current select |
| lock_flag_o | output | 1 | Lock flag, 1 when locked |
| lock_n_o | output | 1 | Lock pin, low when locked |
| test_o | output | 1 | Test output |

## Verification
Every divider output reaches the pins through exactly one register, so `test_o` lags its source by one cycle. For that reason the frequency checks count rising edges over a window that is a whole number of source periods; such a window holds the same number of edges wherever it starts. The lock flag rises one cycle after the fourth good period ends. It therefore reads 0 two periods after reset and 1 six periods after reset, and it reads 0 again within three periods after N is detuned. `cp_hi_o` is combinational from the lock state and the inputs, so it is checked one cycle after a change to `auto_cp_i`. All inputs are driven and all outputs sampled on the falling edge.

// File: rtl/tuner_pll_pkg.sv
package tuner_pll_pkg;
  localparam int REF_W = 11;

  typedef enum logic [1:0] {
    RATIO_512  = 2'b00,
    RATIO_640  = 2'b01,
    RATIO_1024 = 2'b10
  } ratio_e;

  function automatic logic [REF_W-1:0] ref_mod(input logic [1:0] sel);
    case (sel)
      RATIO_512: ref_mod = REF_W'(512);
      RATIO_640: ref_mod = REF_W'(640);
      default:   ref_mod = REF_W'(1024);
    endcase
  endfunction
endpackage

// File: rtl/tpll_div.sv
// Loadable down-counter; modulus sampled only at terminal count.
module tpll_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] mod_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (en_i) begin
      if (cnt_q == '0) cnt_q <= mod_i - W'(1);
      else             cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/tpll_pfd.sv
module tpll_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_p_i,
  input  logic div_p_i,
  output logic up_o,
  output logic dn_o
);
  logic up_d, dn_d;

  always_comb begin
    up_d = up_o | ref_p_i;
    dn_d = dn_o | div_p_i;
    if (up_d && dn_d) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_d;
      dn_o <= dn_d;
    end
  end
endmodule

// File: rtl/tpll_lock.sv
// Width of up/down request per reference period, in crystal strobes.
module tpll_lock #(
  parameter int WID_W    = 8,
  parameter int LOCK_THR = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_tick_i,
  input  logic ref_p_i,
  input  logic busy_i,
  output logic locked_o
);
  localparam int GC_W = $clog2(LOCK_CNT + 1);

  logic [WID_W-1:0] wid_q;
  logic [GC_W-1:0]  good_q, good_d;
  logic             good_per;

  assign good_per = (wid_q < WID_W'(LOCK_THR));
  assign good_d   = !good_per ? '0 :
                    (good_q == GC_W'(LOCK_CNT)) ? good_q : good_q + GC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q    <= '0;
      good_q   <= '0;
      locked_o <= 1'b0;
    end else if (ref_p_i) begin
      wid_q    <= '0;
      good_q   <= good_d;
      locked_o <= (good_d == GC_W'(LOCK_CNT));
    end else if (xtal_tick_i && busy_i && (wid_q != '1)) begin
      wid_q <= wid_q + WID_W'(1);
    end
  end
endmodule

// File: rtl/tuner_pll_core.sv
module tuner_pll_core
  import tuner_pll_pkg::*;
#(
  parameter int N_W      = 15,
  parameter int PRE_DIV  = 8,
  parameter int WID_W    = 8,
  parameter int LOCK_THR = 2,
  parameter int LOCK_CNT = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           osc_tick_i,
  input  logic           xtal_tick_i,
  input  logic [N_W-1:0] n_i,
  input  logic [1:0]     ratio_i,
  input  logic           cp_hi_i,
  input  logic           auto_cp_i,
  input  logic           test_en_i,
  input  logic           test_sel_i,
  output logic           up_o,
  output logic           dn_o,
  output logic           cp_hi_o,
  output logic           lock_flag_o,
  output logic           lock_n_o,
  output logic           test_o
);
  localparam int PRE_W = $clog2(PRE_DIV) + 1;

  logic           pre_tc, div_p, ref_p, locked;
  logic           half_q, test_q;
  logic [N_W-1:0] n_eff;

  assign n_eff = (n_i < N_W'(2)) ? N_W'(2) : n_i;

  generate
    if (PRE_DIV > 1) begin : g_pre
      tpll_div #(.W(PRE_W)) u_pre (
        .clk_i (clk_i), .rst_ni(rst_ni), .en_i(osc_tick_i),
        .mod_i (PRE_W'(PRE_DIV)), .tc_o(pre_tc)
      );
    end else begin : g_nopre
      assign pre_tc = osc_tick_i;
    end
  endgenerate

  tpll_div #(.W(N_W)) u_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pre_tc), .mod_i(n_eff), .tc_o(div_p)
  );

  tpll_div #(.W(REF_W)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(xtal_tick_i),
    .mod_i(ref_mod(ratio_i)), .tc_o(ref_p)
  );

  tpll_pfd u_pfd (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_p_i(ref_p), .div_p_i(div_p),
    .up_o(up_o), .dn_o(dn_o)
  );

  tpll_lock #(.WID_W(WID_W), .LOCK_THR(LOCK_THR), .LOCK_CNT(LOCK_CNT)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .xtal_tick_i(xtal_tick_i), .ref_p_i(ref_p),
    .busy_i(up_o | dn_o), .locked_o(locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      test_q <= 1'b0;
    end else begin
      if (div_p) half_q <= ~half_q;
      test_q <= test_en_i && (test_sel_i ? (div_p ? ~half_q : half_q) : ref_p);
    end
  end

  assign test_o      = test_q;
  assign lock_flag_o = locked;
  assign lock_n_o    = ~locked;
  assign cp_hi_o     = (auto_cp_i && locked) ? 1'b0 : cp_hi_i;
endmodule

// File: rtl/tuner_pll_core_chk.sv
module tuner_pll_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic auto_cp_i,
  input logic cp_hi_i,
  input logic test_en_i,
  input logic up_o,
  input logic dn_o,
  input logic cp_hi_o,
  input logic lock_flag_o,
  input logic lock_n_o,
  input logic test_o
);
  a_r4_up_dn_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  a_r5_lock_pin_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_n_o == !lock_flag_o);

  a_r7_auto_low_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_cp_i && lock_flag_o) |-> !cp_hi_o);

  a_r7_follow_when_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_flag_o |-> (cp_hi_o == cp_hi_i));

  a_r8_test_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> !test_o);
endmodule

bind tuner_pll_core tuner_pll_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .auto_cp_i(auto_cp_i), .cp_hi_i(cp_hi_i),
  .test_en_i(test_en_i), .up_o(up_o), .dn_o(dn_o), .cp_hi_o(cp_hi_o),
  .lock_flag_o(lock_flag_o), .lock_n_o(lock_n_o), .test_o(test_o)
);

// File: tb/tuner_pll_core_bench.sv
`timescale 1ns/1ps
module tuner_pll_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b1, xtal_tick = 1'b1;
  logic [14:0] n = 15'd64;
  logic [1:0]  ratio = 2'b00;
  logic        cp_hi = 1'b1, auto_cp = 1'b1, test_en = 1'b0, test_sel = 1'b0;
  logic        up, dn, cp_hi_o, lock_flag, lock_n, test_o;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tuner_pll_core u_tuner_pll_core (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc_tick), .xtal_tick_i(xtal_tick),
    .n_i(n), .ratio_i(ratio), .cp_hi_i(cp_hi), .auto_cp_i(auto_cp),
    .test_en_i(test_en), .test_sel_i(test_sel), .up_o(up), .dn_o(dn),
    .cp_hi_o(cp_hi_o), .lock_flag_o(lock_flag), .lock_n_o(lock_n), .test_o(test_o)
  );

  function automatic int exp_ref(input logic [1:0] r);
    return (r == 2'b00) ? 512 : (r == 2'b01) ? 640 : 1024;
  endfunction

  function automatic int exp_div(input int nv);
    return 8 * ((nv < 2) ? 2 : nv);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic count_rises(input int len, output int rises);
    logic prev = test_o;
    rises = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (test_o && !prev) rises++;
      prev = test_o;
    end
  endtask

  task automatic count_pump(input int len, output int ups, output int dns);
    ups = 0; dns = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (up) ups++;
      if (dn) dns++;
    end
  endtask

  initial begin
    int r, u, d, nv, per;
    logic [1:0] rs;
    void'($urandom(32'd2024));

    // R9 reset state
    #1;
    @(negedge clk);
    chk(!up && !dn && !lock_flag && lock_n && !test_o, "R9",
        {up, dn, lock_flag, lock_n, test_o}, 5'b00010);
    rst_n = 1'b1;

    // R8 disabled test output stays 0
    test_en = 1'b0; restart();
    count_rises(1200, r);
    chk(r == 0, "R8 disabled", r, 0);

    // R3 each ratio code, reference pulses per window
    test_en = 1'b1; test_sel = 1'b0;
    for (int c = 0; c < 4; c++) begin
      ratio = 2'(c); restart();
      count_rises(3 * exp_ref(ratio), r);
      chk(r == 3, "R3 ref ratio", r, 3);
    end

    // R1 random N, half-divided rising edge per 2 divided periods
    test_sel = 1'b1;
    for (int t = 0; t < 8; t++) begin
      nv = 2 + int'($urandom_range(150));
      n = 15'(nv); restart();
      count_rises(2 * 2 * exp_div(nv), r);
      chk(r == 2, "R1 divide 8N", r, 2);
      count_rises(2 * exp_div(nv) - 8, r);
      chk(r <= 1, "R1 no extra edge", r, 1);
    end

    // R2 clamp of 0 and 1
    for (int v = 0; v < 2; v++) begin
      n = 15'(v); restart();
      count_rises(4 * 2 * exp_div(v), r);
      chk(r == 4, "R2 clamp", r, 4);
    end

    // R4 polarity: fast divided signal -> dn only; slow -> up only
    ratio = 2'b00;
    n = 15'd32; restart();
    repeat (600) @(negedge clk);
    count_pump(2048, u, d);
    chk(u == 0, "R4 fast up", u, 0);
    chk(d == 1024, "R4 fast dn", d, 1024);
    n = 15'd128; restart();
    repeat (600) @(negedge clk);
    count_pump(2048, u, d);
    chk(d == 0, "R4 slow dn", d, 0);
    chk(u > 0, "R4 slow up", u, 1);

    // R7 random programmed current while unlocked (no crystal strobes)
    xtal_tick = 1'b0; restart();
    for (int t = 0; t < 6; t++) begin
      cp_hi = 1'($urandom); auto_cp = 1'($urandom);
      @(negedge clk);
      chk(cp_hi_o == cp_hi, "R7 unlocked follows", cp_hi_o, cp_hi);
    end
    xtal_tick = 1'b1;

    // R5 lock after 4 good periods, R7 auto drop, R6 loss
    n = 15'd64; ratio = 2'b00; cp_hi = 1'b1; auto_cp = 1'b1;
    per = exp_ref(ratio);
    restart();
    repeat (2 * per) @(negedge clk);
    chk(!lock_flag, "R5 not early", lock_flag, 0);
    repeat (4 * per) @(negedge clk);
    chk(lock_flag, "R5 locked flag", lock_flag, 1);
    chk(!lock_n, "R5 lock pin low", lock_n, 0);
    chk(!cp_hi_o, "R7 auto low", cp_hi_o, 0);
    auto_cp = 1'b0; @(negedge clk);
    chk(cp_hi_o, "R7 auto off", cp_hi_o, 1);
    auto_cp = 1'b1; @(negedge clk);
    n = 15'd66;
    repeat (4 * per) @(negedge clk);
    chk(!lock_flag, "R6 lock cleared", lock_flag, 0);
    chk(lock_n, "R6 lock pin high", lock_n, 1);
    chk(cp_hi_o, "R7 high after loss", cp_hi_o, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(180000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule